// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Condition Code

This block is the arithmetic core of a simple accumulator machine with a 24-bit data path. Each operation combines the accumulator with one 24-bit operand word. Load, add, subtract, multiply and divide write their result back into the accumulator. Compare leaves the accumulator alone and records the signed ordering of the two values in a three-state condition code. All integers are two's complement. A jump evaluator reads only that condition code and tells the sequencer whether a less, equal or greater conditional jump is taken.

Operations enter through a valid/ready handshake. An operation is accepted on a rising clock edge where `op_valid` and `op_ready` are both high. While `op_ready` is low, the source must hold `op_code` and `op_word` steady and keep `op_valid` asserted. Every operation except a divide by a non-zero word finishes at its accepting edge, so `op_ready` stays high for these operations. A divide runs through an iterative path: `busy` is high and `op_ready` is low until it finishes. For every operation, `done` pulses for one cycle when the result is visible. The low byte of the accumulator is exposed separately as the byte lane for byte-wide transfers.

Top module: `acc_alu`

## Requirements
- R1: After reset, acc is 0, cc is 01 (equal), op_ready is 1, and busy, done and dz_err are 0.
- R2: Opcode 000 (load) copies op_word into acc.
- R3: Opcode 001 (add) and opcode 010 (subtract) compute acc+word and acc-word modulo 2^24 and write the result to acc.
- R4: Opcode 011 (multiply) writes the low 24 bits of the signed product acc*word to acc.
- R5: Opcode 100 (divide) with a non-zero word writes the signed quotient acc/word, truncated toward zero, to acc. 0x800000 divided by 0xFFFFFF gives 0x800000.
- R6: A divide by a zero word leaves acc unchanged, never raises busy, and pulses dz_err together with done for one cycle in the cycle after acceptance.
- R7: Opcode 101 (compare) leaves acc unchanged and sets cc from the signed comparison of acc with word: 00 less, 01 equal, 10 greater. cc never reads 11.
- R8: cc keeps its value through every operation other than compare.
- R9: jump_taken is combinational from cc and jcond. jcond 00 is taken when cc is 00, 01 when cc is 01, 10 when cc is 10. jcond 11 is never taken.
- R10: Load, add, subtract, multiply and compare raise done in the cycle after the accepting edge and never raise busy. A divide by a non-zero word holds busy high and op_ready low for exactly 25 cycles (data width plus one), then raises done with the quotient in acc.
- R11: acc_byte always equals acc[7:0].
- R12: Opcodes 110 and 111 change neither acc nor cc, and raise done in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request valid |
| op_ready | output | 1 | Unit can accept an operation |
| op_code | input | 3 | Operation select |
| op_word | input | 24 | Operand word |
| jcond | input | 2 | Jump condition to evaluate |
| acc | output | 24 | Accumulator |
| acc_byte | output | 8 | Low byte of the accumulator |
| cc | output | 2 | Condition code |
| jump_taken | output | 1 | Selected jump condition holds |
| busy | output | 1 | Iterative divide in progress |
| done | output | 1 | One-cycle completion pulse |
| dz_err | output | 1 | One-cycle divide-by-zero flag |

## Verification
Directed sequences first cover the cases where a wrong implementation shows a distinct value. Add overflow across 0x7FFFFF separates wrapping arithmetic from saturating arithmetic. Multiplies of mixed signs separate a signed low product from an unsigned one. Divides of every sign pairing separate truncation from flooring. The most negative word divided by minus one, and a divide by zero, probe the two divider edges. Compares of less, equal and greater operands, with each jump condition read after each compare, separate signed from unsigned ordering and a wrong code mapping. A long constrained-random mix follows, with operands biased toward small values, the extremes and zero, and with the reserved opcodes mixed in. It shows that the condition code holds across non-compare operations and that the divide latency stays fixed.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_MUL  = 3'd3,
    OP_DIV  = 3'd4,
    OP_COMP = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    CC_LT  = 2'b00,
    CC_EQ  = 2'b01,
    CC_GT  = 2'b10,
    CC_BAD = 2'b11
  } cc_e;

  typedef enum logic [1:0] {
    JC_LESS    = 2'b00,
    JC_EQUAL   = 2'b01,
    JC_GREATER = 2'b10,
    JC_NEVER   = 2'b11
  } jc_e;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output cc_e          cmp
);
  localparam int unsigned PW = 2 * W;

  logic [W-1:0]  sum_w;
  logic [W-1:0]  dif_w;
  logic [PW-1:0] prod_w;

  assign sum_w  = a + b;
  assign dif_w  = a - b;
  assign prod_w = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});

  always_comb begin
    unique case (op)
      OP_ADD:  res = sum_w;
      OP_SUB:  res = dif_w;
      OP_MUL:  res = prod_w[W-1:0];
      default: res = b;
    endcase
  end

  always_comb begin
    if ($signed(a) < $signed(b))      cmp = CC_LT;
    else if (a == b)                  cmp = CC_EQ;
    else                              cmp = CC_GT;
  end
endmodule

// File: rtl/acc_alu_divider.sv
module acc_alu_divider #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         run,
  output logic         fin,
  output logic [W-1:0] quot
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic [W:0]    rem;
  logic [W-1:0]  qsh;
  logic [W-1:0]  dsr;
  logic          neg_q;

  logic [W-1:0]  mag_a;
  logic [W-1:0]  mag_b;
  logic [W:0]    rem_sh;
  logic          fits;

  assign mag_a  = dividend[W-1] ? (~dividend + 1'b1) : dividend;
  assign mag_b  = divisor[W-1]  ? (~divisor + 1'b1)  : divisor;
  assign rem_sh = {rem[W-1:0], qsh[W-1]};
  assign fits   = (rem_sh >= {1'b0, dsr});

  assign fin  = run && (cnt == '0);
  assign quot = neg_q ? (~qsh + 1'b1) : qsh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      rem   <= '0;
      qsh   <= '0;
      dsr   <= '0;
      neg_q <= 1'b0;
    end else if (start && !run) begin
      run   <= 1'b1;
      cnt   <= CW'(W);
      rem   <= '0;
      qsh   <= mag_a;
      dsr   <= mag_b;
      neg_q <= dividend[W-1] ^ divisor[W-1];
    end else if (run) begin
      if (cnt == '0) begin
        run <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
        rem <= fits ? (rem_sh - {1'b0, dsr}) : rem_sh;
        qsh <= {qsh[W-2:0], fits};
      end
    end
  end

  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= CW'(W)));

  a_r10_fin_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !run);

  a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (rem < {1'b0, dsr}));
endmodule

// File: rtl/acc_alu_jump.sv
module acc_alu_jump
  import acc_alu_pkg::*;
(
  input  cc_e        cc,
  input  logic [1:0] jcond,
  output logic       taken
);
  always_comb begin
    unique case (jc_e'(jcond))
      JC_LESS:    taken = (cc == CC_LT);
      JC_EQUAL:   taken = (cc == CC_EQ);
      JC_GREATER: taken = (cc == CC_GT);
      default:    taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 24,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_code,
  input  logic [W-1:0]      op_word,
  input  logic [1:0]        jcond,
  output logic [W-1:0]      acc,
  output logic [BYTE_W-1:0] acc_byte,
  output logic [1:0]        cc,
  output logic              jump_taken,
  output logic              busy,
  output logic              done,
  output logic              dz_err
);
  op_e          op;
  logic         fire;
  logic         word_zero;
  logic         div_start;
  logic         div_run;
  logic         div_fin;
  logic [W-1:0] div_q;
  logic [W-1:0] alu_res;
  cc_e          alu_cmp;
  cc_e          cc_q;

  assign op        = op_e'(op_code);
  assign fire      = op_valid && op_ready;
  assign word_zero = (op_word == '0);
  assign div_start = fire && (op == OP_DIV) && !word_zero;

  assign op_ready  = !div_run;
  assign busy      = div_run;
  assign cc        = cc_q;
  assign acc_byte  = acc[BYTE_W-1:0];

  acc_alu_arith #(.W(W)) u_arith (
    .op  (op),
    .a   (acc),
    .b   (op_word),
    .res (alu_res),
    .cmp (alu_cmp)
  );

  acc_alu_divider #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (acc),
    .divisor  (op_word),
    .run      (div_run),
    .fin      (div_fin),
    .quot     (div_q)
  );

  acc_alu_jump u_jump (
    .cc    (cc_q),
    .jcond (jcond),
    .taken (jump_taken)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      cc_q   <= CC_EQ;
      done   <= 1'b0;
      dz_err <= 1'b0;
    end else begin
      done   <= 1'b0;
      dz_err <= 1'b0;
      if (div_fin) begin
        acc  <= div_q;
        done <= 1'b1;
      end else if (fire) begin
        unique case (op)
          OP_LOAD, OP_ADD, OP_SUB, OP_MUL: begin
            acc  <= alu_res;
            done <= 1'b1;
          end
          OP_DIV: begin
            if (word_zero) begin
              dz_err <= 1'b1;
              done   <= 1'b1;
            end
          end
          OP_COMP: begin
            cc_q <= alu_cmp;
            done <= 1'b1;
          end
          default: done <= 1'b1;
        endcase
      end
    end
  end

  a_r7_cc_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cc_q != CC_BAD);

  a_r8_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && op == OP_COMP) |=> $stable(cc_q));

  a_r7_comp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_COMP) |=> $stable(acc));

  a_r6_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_DIV && word_zero) |=> (dz_err && done && !busy && $stable(acc)));

  a_r10_div_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |=> (busy && !done));

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r12_reserved_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (op == OP_RSV6 || op == OP_RSV7)) |=> ($stable(acc) && $stable(cc_q) && done));
endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;
  localparam int W = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic          op_ready;
  logic [2:0]    op_code = '0;
  logic [W-1:0]  op_word = '0;
  logic [1:0]    jcond = '0;
  logic [W-1:0]  acc;
  logic [7:0]    acc_byte;
  logic [1:0]    cc;
  logic          jump_taken;
  logic          busy;
  logic          done;
  logic          dz_err;

  int n_chk = 0;
  int n_bad = 0;

  logic [W-1:0] m_acc = '0;
  logic [1:0]   m_cc  = 2'b01;

  always #5 clk = ~clk;

  acc_alu uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_word(op_word), .jcond(jcond), .acc(acc),
    .acc_byte(acc_byte), .cc(cc), .jump_taken(jump_taken), .busy(busy),
    .done(done), .dz_err(dz_err)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [W-1:0] f_div(logic [W-1:0] a, logic [W-1:0] b);
    logic signed [W:0] sa;
    logic signed [W:0] sb;
    logic signed [W:0] q;
    sa = $signed({a[W-1], a});
    sb = $signed({b[W-1], b});
    q  = sa / sb;
    return q[W-1:0];
  endfunction

  function automatic logic [1:0] f_cmp(logic [W-1:0] a, logic [W-1:0] b);
    if ($signed(a) < $signed(b)) return 2'b00;
    if (a == b) return 2'b01;
    return 2'b10;
  endfunction

  function automatic logic f_jump(logic [1:0] c, logic [1:0] j);
    if (j == 2'b11) return 1'b0;
    return c == j;
  endfunction

  task automatic run_op(logic [2:0] opc, logic [W-1:0] word);
    int busy_n;
    int guard;
    logic exp_err;
    logic long_div;
    logic [W-1:0] prod;
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = opc;
    op_word  = word;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    exp_err  = 1'b0;
    long_div = 1'b0;
    case (opc)
      3'd0: m_acc = word;
      3'd1: m_acc = m_acc + word;
      3'd2: m_acc = m_acc - word;
      3'd3: begin prod = m_acc * word; m_acc = prod; end
      3'd4: begin
        if (word == '0) exp_err = 1'b1;
        else begin m_acc = f_div(m_acc, word); long_div = 1'b1; end
      end
      3'd5: m_cc = f_cmp(m_acc, word);
      default: ;
    endcase
    busy_n = 0;
    guard  = 0;
    forever begin
      @(negedge clk);
      if (done) break;
      if (busy) begin
        busy_n++;
        if (op_ready) check("R10 ready low while busy", 32'(op_ready), 32'd0);
      end
      guard++;
      if (guard > 100) begin
        check("R10 done never arrived", 32'd0, 32'd1);
        break;
      end
    end
    if (opc == 3'd4) begin
      if (word == '0) check("R6 div zero busy cycles", busy_n, 0);
      else            check("R10 divide busy cycles", busy_n, W + 1);
    end else begin
      check("R10 single-cycle no busy", busy_n, 0);
    end
    case (opc)
      3'd0:    check("R2 load result", 32'(acc), 32'(m_acc));
      3'd1, 3'd2: check("R3 add/sub result", 32'(acc), 32'(m_acc));
      3'd3:    check("R4 multiply result", 32'(acc), 32'(m_acc));
      3'd4:    check(long_div ? "R5 divide result" : "R6 div zero keeps acc", 32'(acc), 32'(m_acc));
      3'd5:    check("R7 compare keeps acc", 32'(acc), 32'(m_acc));
      default: check("R12 reserved keeps acc", 32'(acc), 32'(m_acc));
    endcase
    check(opc == 3'd5 ? "R7 compare code" : "R8 cc held", 32'(cc), 32'(m_cc));
    check("R6 dz_err flag", 32'(dz_err), 32'(exp_err));
    check("R11 byte lane", 32'(acc_byte), 32'(m_acc[7:0]));
    for (int j = 0; j < 4; j++) begin
      jcond = 2'(j);
      #1;
      check("R9 jump taken", 32'(jump_taken), 32'(f_jump(m_cc, 2'(j))));
    end
  endtask

  function automatic logic [W-1:0] pick_word();
    int k;
    k = int'($urandom_range(0, 3));
    case (k)
      0: return W'($signed(32'($urandom_range(0, 31)) - 32'sd16));
      1: case ($urandom_range(0, 4))
           0: return 24'h000000;
           1: return 24'h000001;
           2: return 24'hFFFFFF;
           3: return 24'h7FFFFF;
           default: return 24'h800000;
         endcase
      default: return W'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog expired", 32'd0, 32'd1);
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset acc", 32'(acc), 32'd0);
    check("R1 reset cc", 32'(cc), 32'd1);
    check("R1 reset ready", 32'(op_ready), 32'd1);
    check("R1 reset busy", 32'(busy), 32'd0);
    check("R1 reset done", 32'(done), 32'd0);
    check("R1 reset dz_err", 32'(dz_err), 32'd0);
    rst_n = 1'b1;

    run_op(3'd0, 24'd5);
    run_op(3'd1, 24'd7);
    run_op(3'd2, 24'd20);
    run_op(3'd0, 24'h7FFFFF);
    run_op(3'd1, 24'd1);
    run_op(3'd0, 24'hFFFFFD);
    run_op(3'd3, 24'd5);
    run_op(3'd3, 24'hFFFFF0);
    run_op(3'd0, 24'd7);
    run_op(3'd4, 24'hFFFFFE);
    run_op(3'd0, 24'hFFFFF9);
    run_op(3'd4, 24'd2);
    run_op(3'd0, 24'h800000);
    run_op(3'd4, 24'hFFFFFF);
    run_op(3'd4, 24'd0);
    run_op(3'd0, 24'd10);
    run_op(3'd5, 24'd11);
    run_op(3'd5, 24'd10);
    run_op(3'd5, 24'hFFFFFF);
    run_op(3'd6, 24'd3);
    run_op(3'd7, 24'd0);
    run_op(3'd1, 24'd1);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      run_op(o, pick_word());
    end

    summary();
  end
endmodule